// File: doc/BRIEF.md
# Qualified Reset Sequencer

This block turns an active-low, asynchronous reset request from the board into the reset controls of a small 8-bit processor core. The request is first brought into the processor clock domain through a flop chain. A run-length counter then checks that the synchronized request has stayed low for a minimum number of consecutive clock cycles. A request that is too short is treated as a glitch and does not reset the core.

Once the request qualifies, the block holds the core reset and a set of derived strobes. These strobes clear the program counter and the instruction register, force every maskable interrupt into the masked state, switch off the serial output latch and ask for the data, address and control buses to float. The non-maskable trap input stays enabled at all times.

A separate active-high peripheral reset goes to the rest of the board. It follows the synchronized request directly and needs no qualification. Every output comes straight from a flop. The block's own flops are initialised by a synchronous, active-high local reset.

Top module: `qual_reset_seq`

## Requirements
- R1: While and just after the local reset `rst` is high, every reset output (`core_rst`, `pc_clr`, `ir_clr`, all bits of `int_mask_force`, `sod_off`, `bus_hiz`, `periph_rst`) is 0 and `trap_en` is 1.
- R2: `core_rst` goes to 1 only after the synchronized request has been low for MIN_LOW consecutive samples. With the defaults (SYNC_STAGES=2, MIN_LOW=3), a request that goes low just before clock edge k gives `core_rst` = 1 from edge k+4.
- R3: `periph_rst` goes to 1 on the first synchronized low sample (edge k+2 with the defaults), without qualification, and stays 1 for as long as the request stays low.
- R4: A low request shorter than MIN_LOW synchronized samples causes no core reset. A high sample restarts the count, so two short pulses separated by one high cycle do not add up.
- R5: Whenever `core_rst` is 1, `pc_clr` and `ir_clr` are both 1.
- R6: Whenever `core_rst` is 1, every bit of `int_mask_force` (N_MASKABLE bits, bit i masks maskable interrupt i) is 1, and `trap_en` stays 1 in every cycle.
- R7: Whenever `core_rst` is 1, `sod_off` and `bus_hiz` are both 1.
- R8: All reset outputs, including `periph_rst`, return to 0 on the first clock edge at which the synchronized request is seen high. With the defaults this is edge k+2 after the request rises before edge k.
- R9: A request held low for any length keeps every reset output asserted throughout, because the run-length counter saturates at MIN_LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high local reset of the sequencer flops |
| rst_req_n | input | 1 | Asynchronous active-low reset request from the board |
| core_rst | output | 1 | Qualified internal core reset, active high |
| pc_clr | output | 1 | Program counter clear strobe |
| ir_clr | output | 1 | Instruction register clear strobe |
| int_mask_force | output | N_MASKABLE | Per-interrupt force-mask for the maskable interrupts |
| trap_en | output | 1 | Enable of the non-maskable trap, held high |
| sod_off | output | 1 | Forces the serial output data latch off |
| bus_hiz | output | 1 | Requests tri-state on data, address and control buses |
| periph_rst | output | 1 | Active-high reset for other chips on the board |

## Verification
The bench builds the block with SYNC_STAGES=2, MIN_LOW=3 and N_MASKABLE=4. The short qualification window makes the exact boundary reachable in a few cycles: pulses of one and two samples, a pulse of exactly three samples, and a pulse one sample longer. With two synchronizer stages, the bench can predict every output edge from the input history alone. A 40-cycle hold runs the counter far past its saturation point. Four mask bits are enough to show that the force-mask is applied to all interrupts at once.

// File: rtl/qrs_pkg.sv
package qrs_pkg;

  typedef struct packed {
    logic core;
    logic pc_clr;
    logic ir_clr;
    logic sod_off;
    logic bus_hiz;
    logic periph;
  } rst_ctrl_t;

  localparam rst_ctrl_t CTRL_IDLE = '{default: 1'b0};

  // Build the control bundle from the qualified and raw low indications.
  function automatic rst_ctrl_t ctrl_decode(input logic qualified, input logic seen_low);
    rst_ctrl_t c;
    c.core    = qualified;
    c.pc_clr  = qualified;
    c.ir_clr  = qualified;
    c.sod_off = qualified;
    c.bus_hiz = qualified;
    c.periph  = seen_low;
    return c;
  endfunction

endpackage

// File: rtl/qrs_sync.sv
module qrs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_n,
  output logic sync_n
);

  generate
    if (STAGES <= 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk) begin
        if (rst) stage_q <= 1'b1;
        else     stage_q <= async_n;
      end
      assign sync_n = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], async_n};
      end
      assign sync_n = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/qrs_qualify.sv
module qrs_qualify #(
  parameter int MIN_LOW = 3,
  parameter int CNT_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seen_low,
  output logic [CNT_W-1:0] run_cnt,
  output logic             qualify_nxt
);

  localparam logic [CNT_W-1:0] LIM  = CNT_W'(MIN_LOW);
  localparam logic [CNT_W-1:0] EDGE = CNT_W'(MIN_LOW - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (!seen_low)   cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  // The sample taken at this edge completes the run when the count already holds MIN_LOW-1.
  assign qualify_nxt = seen_low && (cnt_q >= EDGE);
  assign run_cnt     = cnt_q;

  // R9
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst) cnt_q <= LIM);

  // R4
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst) !seen_low |=> cnt_q == '0);

endmodule

// File: rtl/qrs_fanout.sv
module qrs_fanout
  import qrs_pkg::*;
#(
  parameter int N_MASKABLE = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  qualify_nxt,
  input  logic                  seen_low,
  output logic                  core_rst,
  output logic                  pc_clr,
  output logic                  ir_clr,
  output logic [N_MASKABLE-1:0] int_mask_force,
  output logic                  trap_en,
  output logic                  sod_off,
  output logic                  bus_hiz,
  output logic                  periph_rst
);

  rst_ctrl_t ctrl_q;
  logic      trap_q;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= CTRL_IDLE;
    else     ctrl_q <= ctrl_decode(qualify_nxt, seen_low);
  end

  // The trap enable is never cleared, in or out of reset.
  always_ff @(posedge clk) begin
    if (rst) trap_q <= 1'b1;
    else     trap_q <= 1'b1;
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_MASKABLE; gi++) begin : g_mask
      logic mask_q;
      always_ff @(posedge clk) begin
        if (rst) mask_q <= 1'b0;
        else     mask_q <= qualify_nxt;
      end
      assign int_mask_force[gi] = mask_q;
    end
  endgenerate

  assign core_rst   = ctrl_q.core;
  assign pc_clr     = ctrl_q.pc_clr;
  assign ir_clr     = ctrl_q.ir_clr;
  assign sod_off    = ctrl_q.sod_off;
  assign bus_hiz    = ctrl_q.bus_hiz;
  assign periph_rst = ctrl_q.periph;
  assign trap_en    = trap_q;

endmodule

// File: rtl/qual_reset_seq.sv
module qual_reset_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 3,
  parameter int N_MASKABLE  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rst_req_n,
  output logic                  core_rst,
  output logic                  pc_clr,
  output logic                  ir_clr,
  output logic [N_MASKABLE-1:0] int_mask_force,
  output logic                  trap_en,
  output logic                  sod_off,
  output logic                  bus_hiz,
  output logic                  periph_rst
);

  localparam int CNT_W = $clog2(MIN_LOW + 1);
  localparam logic [CNT_W-1:0] EDGE = CNT_W'(MIN_LOW - 1);

  logic             req_sync_n;
  logic             seen_low;
  logic [CNT_W-1:0] run_cnt;
  logic             qualify_nxt;

  qrs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_n (rst_req_n),
    .sync_n  (req_sync_n)
  );

  assign seen_low = ~req_sync_n;

  qrs_qualify #(.MIN_LOW(MIN_LOW), .CNT_W(CNT_W)) u_qualify (
    .clk         (clk),
    .rst         (rst),
    .seen_low    (seen_low),
    .run_cnt     (run_cnt),
    .qualify_nxt (qualify_nxt)
  );

  qrs_fanout #(.N_MASKABLE(N_MASKABLE)) u_fanout (
    .clk            (clk),
    .rst            (rst),
    .qualify_nxt    (qualify_nxt),
    .seen_low       (seen_low),
    .core_rst       (core_rst),
    .pc_clr         (pc_clr),
    .ir_clr         (ir_clr),
    .int_mask_force (int_mask_force),
    .trap_en        (trap_en),
    .sod_off        (sod_off),
    .bus_hiz        (bus_hiz),
    .periph_rst     (periph_rst)
  );

  // R2
  qual_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst) |-> ($past(seen_low) && ($past(run_cnt) >= EDGE)));

  // R3
  periph_cover_chk: assert property (@(posedge clk) disable iff (rst)
    core_rst |-> periph_rst);

  // R8
  release_chk: assert property (@(posedge clk) disable iff (rst)
    !seen_low |=> (!core_rst && !periph_rst));

endmodule

// File: tb/qual_reset_seq_tb.sv
module qual_reset_seq_tb;

  localparam int SYNC = 2;
  localparam int MINL = 3;
  localparam int NM   = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rst_req_n = 1'b1;
  logic          core_rst, pc_clr, ir_clr, trap_en, sod_off, bus_hiz, periph_rst;
  logic [NM-1:0] int_mask_force;

  always #2 clk = ~clk;

  qual_reset_seq #(.SYNC_STAGES(SYNC), .MIN_LOW(MINL), .N_MASKABLE(NM)) u_dut (
    .clk(clk), .rst(rst), .rst_req_n(rst_req_n),
    .core_rst(core_rst), .pc_clr(pc_clr), .ir_clr(ir_clr),
    .int_mask_force(int_mask_force), .trap_en(trap_en),
    .sod_off(sod_off), .bus_hiz(bus_hiz), .periph_rst(periph_rst)
  );

  typedef struct {
    logic  core;
    logic  periph;
    string phase;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] hist = '1;
  string       phase = "idle";
  int          checks = 0;
  int          fails  = 0;
  bit          finished = 1'b0;

  task automatic check(input string req, input string ph, input logic [NM-1:0] act, input logic [NM-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) at %0t: actual %b expected %b", req, ph, $time, act, exp);
    end
  endtask

  // Driver: applies one input per cycle and predicts the outputs after the next edge.
  task automatic drive(input logic v, input int n);
    exp_t e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rst_req_n = v;
      hist = {hist[30:0], v};
      e.periph = !hist[SYNC];
      e.core   = 1'b1;
      for (int j = 0; j < MINL; j++) if (hist[SYNC + j]) e.core = 1'b0;
      e.phase  = phase;
      sb.push_back(e);
    end
  endtask

  // Monitor: compares shortly after each edge.
  always begin
    exp_t e;
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      check("R2", e.phase, NM'(core_rst), NM'(e.core));
      check("R3", e.phase, NM'(periph_rst), NM'(e.periph));
      check("R5", e.phase, NM'({pc_clr, ir_clr}), NM'({e.core, e.core}));
      check("R6", e.phase, int_mask_force, {NM{e.core}});
      check("R6", e.phase, NM'(trap_en), NM'(1'b1));
      check("R7", e.phase, NM'({sod_off, bus_hiz}), NM'({e.core, e.core}));
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: local reset state
    check("R1", "local reset", NM'({core_rst, pc_clr, ir_clr, sod_off, bus_hiz, periph_rst}), '0);
    check("R1", "local reset", int_mask_force, '0);
    check("R1", "local reset", NM'(trap_en), NM'(1'b1));
    rst = 1'b0;
    phase = "R1 idle after reset";
    drive(1'b1, 4);
    phase = "R4 short pulses";
    drive(1'b0, 2); drive(1'b1, 1); drive(1'b0, 2); drive(1'b1, 6);
    drive(1'b0, 1); drive(1'b1, 5);
    phase = "R2 minimal qualifying pulse";
    drive(1'b0, MINL); drive(1'b1, 8);
    phase = "R9 long hold";
    drive(1'b0, 40);
    phase = "R8 release";
    drive(1'b1, 8);
    phase = "R2 mixed runs";
    drive(1'b0, 4); drive(1'b1, 1); drive(1'b0, 3); drive(1'b1, 1);
    drive(1'b0, 2); drive(1'b1, 8);
    while (sb.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule